// File: doc/BRIEF.md
# Six-Channel Down-Counting Interval Timer Bank

This block holds a set of independent 32-bit down-counters behind a simple memory-mapped register port. Each channel has a control word, an interval (reload) value and a live count. A channel counts down once per cycle of a shared tick enable. It can run periodically, reloading from its interval, or fire once and then disable itself. Every expiry sets that channel's bit in a shared interrupt-status register. Software clears status bits by writing ones to them. Each channel drives its own level interrupt, gated by a shared interrupt-enable register.

The register port is a single-cycle strobe interface. A write takes effect on the clock edge that samples `wr_en`. Read data is combinational and valid in the same cycle as `rd_en`; it is zero when `rd_en` is low. The address space is a 10-bit (1 KB) byte window. Channel registers sit in 16-byte slots starting at slot 1. Two scratch words are provided as plain storage.

Top module: `pit_bank`

## Requirements
- R1: Address decode. Offset 0x000 is interrupt-enable and 0x004 is interrupt-status. Channel c (0..5) occupies the 16-byte slot whose number, address bits [7:4], equals c+1, with address bits [9:8] zero. Within a slot, address bits [3:0] select a register: 0x0 is control, 0x4 is interval, 0x8 is count.
- R2: Control bits. Bit 0 is enable. Bit 7 selects single-shot when 1 and periodic when 0. Bit 1 is a reload action: a control write with bit 1 set loads the count from the interval register on the same edge. Bit 1 always reads back as 0, and all other control bits read back as written.
- R3: While enable is 0, the channel's count holds its value.
- R4: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. Only bits [5:0] of status and interrupt-enable are stored; upper bits read 0.
- R5: On a tick with enable set, a count above 1 decrements by one. A count of 1 or 0 is an expiry, which sets the channel's status bit. In periodic mode an expiry loads the count from interval on the same edge.
- R6: On a single-shot expiry the count becomes 0 and hardware clears the control enable bit.
- R7: Reading count returns the live counter. Writing count loads the counter directly. Writing interval changes only later reloads, not the current count.
- R8: irq[c] is a level equal to status bit c AND interrupt-enable bit c.
- R9: After reset, interrupt-enable, status, every interval and every count are 0, and every control register reads 0x00000010, which leaves all channels stopped.
- R10: Reads of undecoded offsets, including slots 0 and 7 to 15 and unused words in a channel slot, return 0. Writes to those offsets change no register.
- R11: Offsets 0x100 and 0x104 are read/write scratch words with no other effect.
- R12: A write to a channel's control or count register overrides that channel's tick action in the same cycle. An expiry that sets a status bit wins over a write-one-to-clear of that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Countdown tick enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Byte address within the 1 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when not reading |
| irq | output | 6 | Per-channel level interrupts |

## Verification
Two functions can land on the same edge. The first pair is a status bit being set by an expiry and the same bit being cleared by a write-one-to-clear. The second pair is a tick decrement and a software write to that channel's control or count register. The bench forces both collisions on purpose. It writes all-ones to the status register on every cycle while a channel with a short interval is ticking. It also issues control and count writes on ticking cycles. It judges the outcome against a behavioural model that has the set-wins and write-wins priorities built in, and compares irq and read data every cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DW = 32;
  localparam int AW = 10;
  typedef logic [DW-1:0] word_t;

  localparam logic [AW-1:0] OFF_IEN = 10'h000;
  localparam logic [AW-1:0] OFF_IST = 10'h004;
  localparam logic [AW-1:0] OFF_SCA = 10'h100;
  localparam logic [AW-1:0] OFF_SCB = 10'h104;

  localparam int CTL_EN      = 0;
  localparam int CTL_RLD     = 1;
  localparam int CTL_ONESHOT = 7;
  localparam word_t CTL_RST  = 32'h0000_0010;

  typedef enum logic [1:0] {F_NONE, F_CTL, F_IVL, F_CNT} fld_e;

  function automatic fld_e field_of(logic [3:0] lo);
    case (lo)
      4'h0:    return F_CTL;
      4'h4:    return F_IVL;
      4'h8:    return F_CNT;
      default: return F_NONE;
    endcase
  endfunction

  function automatic logic at_expiry(word_t c);
    return c <= word_t'(1);
  endfunction
endpackage

// File: rtl/pit_regdec.sv
module pit_regdec
  import pit_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic [AW-1:0]  addr,
  output logic           hit_ien,
  output logic           hit_ist,
  output logic           hit_sca,
  output logic           hit_scb,
  output logic [NCH-1:0] ch_hit,
  output fld_e           fld
);
  logic [3:0] slot;
  logic       page0;

  assign slot    = addr[7:4];
  assign page0   = (addr[AW-1:8] == '0);
  assign fld     = field_of(addr[3:0]);
  assign hit_ien = (addr == OFF_IEN);
  assign hit_ist = (addr == OFF_IST);
  assign hit_sca = (addr == OFF_SCA);
  assign hit_scb = (addr == OFF_SCB);

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    assign ch_hit[g] = page0 && (slot == 4'(g + 1)) && (fld != F_NONE);
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_en,
  input  logic  wr_ctl,
  input  logic  wr_ivl,
  input  logic  wr_cnt,
  input  word_t wdata,
  output word_t ctl,
  output word_t ivl,
  output word_t cnt,
  output logic  expire
);
  logic step;

  assign step   = tick_en && ctl[CTL_EN] && !wr_ctl && !wr_cnt;
  assign expire = step && at_expiry(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= CTL_RST;
      ivl <= '0;
      cnt <= '0;
    end else begin
      if (wr_ivl) ivl <= wdata;
      if (wr_ctl) begin
        ctl <= wdata & ~(word_t'(1) << CTL_RLD);
        if (wdata[CTL_RLD]) cnt <= ivl;
      end else if (wr_cnt) begin
        cnt <= wdata;
      end else if (expire) begin
        if (ctl[CTL_ONESHOT]) begin
          cnt         <= '0;
          ctl[CTL_EN] <= 1'b0;
        end else begin
          cnt <= ivl;
        end
      end else if (step) begin
        cnt <= cnt - word_t'(1);
      end
    end
  end
endmodule

// File: rtl/pit_bank.sv
module pit_bank
  import pit_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [9:0]     addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic [NCH-1:0] irq
);
  logic           hit_ien, hit_ist, hit_sca, hit_scb;
  logic [NCH-1:0] ch_hit;
  fld_e           fld;

  logic [NCH-1:0] ien_q, ist_q;
  word_t          sca_q, scb_q;
  logic [NCH-1:0][DW-1:0] ctl_q, ivl_q, cnt_q;

  // named internal events for the checker
  logic [NCH-1:0] ch_expire;
  logic [NCH-1:0] ch_run;
  logic [NCH-1:0] ch_oneshot;
  logic [NCH-1:0] clr_mask;

  pit_regdec #(.NCH(NCH)) u_dec (
    .addr    (addr),
    .hit_ien (hit_ien),
    .hit_ist (hit_ist),
    .hit_sca (hit_sca),
    .hit_scb (hit_scb),
    .ch_hit  (ch_hit),
    .fld     (fld)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pit_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_ctl  (wr_en && ch_hit[g] && (fld == F_CTL)),
      .wr_ivl  (wr_en && ch_hit[g] && (fld == F_IVL)),
      .wr_cnt  (wr_en && ch_hit[g] && (fld == F_CNT)),
      .wdata   (wdata),
      .ctl     (ctl_q[g]),
      .ivl     (ivl_q[g]),
      .cnt     (cnt_q[g]),
      .expire  (ch_expire[g])
    );
    assign ch_run[g]     = ctl_q[g][CTL_EN];
    assign ch_oneshot[g] = ctl_q[g][CTL_ONESHOT];
  end

  assign clr_mask = (wr_en && hit_ist) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      ist_q <= '0;
      sca_q <= '0;
      scb_q <= '0;
    end else begin
      ist_q <= (ist_q & ~clr_mask) | ch_expire;
      if (wr_en && hit_ien) ien_q <= wdata[NCH-1:0];
      if (wr_en && hit_sca) sca_q <= wdata;
      if (wr_en && hit_scb) scb_q <= wdata;
    end
  end

  assign irq = ist_q & ien_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_ien) rdata = DW'(ien_q);
      if (hit_ist) rdata = DW'(ist_q);
      if (hit_sca) rdata = sca_q;
      if (hit_scb) rdata = scb_q;
      for (int i = 0; i < NCH; i++) begin
        if (ch_hit[i]) begin
          case (fld)
            F_CTL:   rdata = ctl_q[i];
            F_IVL:   rdata = ivl_q[i];
            F_CNT:   rdata = cnt_q[i];
            default: rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pit_bank_sva.sv
module pit_bank_sva
  import pit_pkg::*;
#(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [9:0]     addr,
  input logic [31:0]    wdata,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] ist,
  input logic [NCH-1:0] ien,
  input logic [NCH-1:0] expire,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] oneshot
);
  logic st_wr;
  assign st_wr = wr_en && (addr == OFF_IST);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r5_expiry_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> ist[g]);
    a_r6_oneshot_self_disables: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] && oneshot[g] |=> !run[g]);
    a_r3_no_expiry_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |-> run[g]);
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr && wdata[g] && !expire[g] |=> !ist[g]);
    a_r12_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr && wdata[g] && expire[g] |=> ist[g]);
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> (ist[g] && ien[g]));
  end
endmodule

bind pit_bank pit_bank_sva #(.NCH(NCH)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq     (irq),
  .ist     (ist_q),
  .ien     (ien_q),
  .expire  (ch_expire),
  .run     (ch_run),
  .oneshot (ch_oneshot)
);

// File: tb/test_pit_bank.sv
`timescale 1ns/1ps
module test_pit_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;

  integer vectors = 0, miscompares = 0;
  bit     finished = 1'b0;

  // behavioural reference state
  logic [31:0] m_ctl [6];
  logic [31:0] m_ivl [6];
  logic [31:0] m_cnt [6];
  logic [5:0]  m_ien, m_ist;
  logic [31:0] m_sa, m_sb;

  pit_bank i_pit_bank (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic m_reset();
    for (int c = 0; c < 6; c++) begin
      m_ctl[c] = 32'h10; m_ivl[c] = 0; m_cnt[c] = 0;
    end
    m_ien = 0; m_ist = 0; m_sa = 0; m_sb = 0;
  endtask

  function automatic int slot_chan(logic [9:0] a);
    if (a[9:8] != 2'b00) return -1;
    if (a[7:4] < 1 || a[7:4] > 6) return -1;
    return int'(a[7:4]) - 1;
  endfunction

  function automatic logic [31:0] m_read(logic [9:0] a);
    int c;
    c = slot_chan(a);
    if (a == 10'h000) return {26'd0, m_ien};
    if (a == 10'h004) return {26'd0, m_ist};
    if (a == 10'h100) return m_sa;
    if (a == 10'h104) return m_sb;
    if (c >= 0) begin
      if (a[3:0] == 4'h0) return m_ctl[c];
      if (a[3:0] == 4'h4) return m_ivl[c];
      if (a[3:0] == 4'h8) return m_cnt[c];
    end
    return 32'd0;
  endfunction

  task automatic m_update(bit w, logic [9:0] a, logic [31:0] d, bit t);
    logic [5:0] fired = 0;
    int wc;
    wc = slot_chan(a);
    for (int c = 0; c < 6; c++) begin
      bit touched;
      touched = w && (wc == c) && (a[3:0] == 4'h0 || a[3:0] == 4'h8);
      if (t && m_ctl[c][0] && !touched) begin
        if (m_cnt[c] == 0 || m_cnt[c] == 1) begin
          fired[c] = 1'b1;
          if (m_ctl[c][7]) begin m_cnt[c] = 0; m_ctl[c][0] = 1'b0; end
          else m_cnt[c] = m_ivl[c];
        end else m_cnt[c] = m_cnt[c] - 1;
      end
    end
    if (w) begin
      if (a == 10'h000) m_ien = d[5:0];
      else if (a == 10'h004) m_ist = m_ist & ~d[5:0];
      else if (a == 10'h100) m_sa = d;
      else if (a == 10'h104) m_sb = d;
      else if (wc >= 0) begin
        if (a[3:0] == 4'h0) begin
          m_ctl[wc] = {d[31:2], 1'b0, d[0]};
          if (d[1]) m_cnt[wc] = m_ivl[wc];
        end else if (a[3:0] == 4'h4) m_ivl[wc] = d;
        else if (a[3:0] == 4'h8) m_cnt[wc] = d;
      end
    end
    m_ist = m_ist | fired;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit w, bit r, logic [9:0] a, logic [31:0] d, bit t, string req);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = t;
    #1;
    check("R8", "irq", {26'd0, irq}, {26'd0, m_ist & m_ien});
    if (r) check(req, $sformatf("rdata@%h", a), rdata, m_read(a));
    @(posedge clk);
    m_update(w, a, d, t);
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d, bit t = 0);
    step(1, 0, a, d, t, "R1");
  endtask
  task automatic rd(logic [9:0] a, string req, bit t = 0);
    step(0, 1, a, 32'd0, t, req);
  endtask
  task automatic idle(int n, bit t);
    for (int i = 0; i < n; i++) step(0, 0, 10'h0, 32'd0, t, "R5");
  endtask

  function automatic logic [9:0] cb(int c, int f);
    return 10'((c + 1) * 16 + f);
  endfunction

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset values
    for (int c = 0; c < 6; c++) begin
      rd(cb(c, 0), "R9"); rd(cb(c, 4), "R9"); rd(cb(c, 8), "R9");
    end
    rd(10'h000, "R9"); rd(10'h004, "R9");
    idle(4, 1);  // ticks while stopped: R3
    rd(cb(0, 8), "R3");

    // R10 undecoded offsets, R11 scratch
    wr(10'h00C, 32'hFFFF_FFFF); wr(10'h070, 32'h1234_5678); wr(cb(2, 12), 32'hDEAD_BEEF);
    wr(10'h008, 32'hFFFF_FFFF);
    rd(10'h00C, "R10"); rd(10'h070, "R10"); rd(cb(2, 12), "R10"); rd(10'h3FC, "R10");
    rd(10'h000, "R10"); rd(cb(2, 0), "R10"); rd(cb(5, 0), "R10");
    wr(10'h100, 32'hA5A5_0001); wr(10'h104, 32'h0F0F_F0F0);
    rd(10'h100, "R11"); rd(10'h104, "R11");

    // R1/R2/R5/R8: channel 0 periodic interval 3
    wr(10'h000, 32'hFFFF_FFFF);
    rd(10'h000, "R4");
    wr(cb(0, 4), 32'd3);
    rd(cb(0, 8), "R7");
    wr(cb(0, 0), 32'h0000_0013);
    rd(cb(0, 0), "R2"); rd(cb(0, 8), "R2");
    for (int i = 0; i < 8; i++) rd(cb(0, 8), "R5", 1);
    rd(10'h004, "R5");
    wr(10'h004, 32'h0000_0001);
    rd(10'h004, "R4");

    // R6: channel 1 single-shot interval 2
    wr(cb(1, 4), 32'd2);
    wr(cb(1, 0), 32'h0000_0083);
    for (int i = 0; i < 4; i++) rd(cb(1, 0), "R6", 1);
    rd(cb(1, 8), "R6");
    idle(3, 1);
    rd(cb(1, 8), "R6");

    // R7: interval write affects only later reloads; count write loads counter
    wr(cb(0, 4), 32'd5, 1);
    rd(cb(0, 8), "R7", 1);
    wr(cb(0, 8), 32'd40, 1);
    rd(cb(0, 8), "R7");
    for (int i = 0; i < 3; i++) rd(cb(0, 8), "R7", 1);

    // R3: stop channel 0, counter holds
    wr(cb(0, 0), 32'h0000_0010, 1);
    idle(5, 1);
    rd(cb(0, 8), "R3", 1);

    // R12: status clear collides with expiry (interval 0 fires every tick)
    wr(cb(2, 4), 32'd0);
    wr(cb(2, 0), 32'h0000_0001, 1);
    for (int i = 0; i < 6; i++) step(1, 0, 10'h004, 32'hFFFF_FFFF, 1, "R12");
    rd(10'h004, "R12");
    step(1, 0, cb(2, 8), 32'd9, 1, "R12");
    rd(cb(2, 8), "R12");
    wr(cb(2, 0), 32'h0000_0003, 1);
    rd(cb(2, 8), "R12");
    wr(10'h004, 32'h0000_003F);
    rd(10'h004, "R4");

    // mixed traffic across all channels
    for (int i = 0; i < 1500; i++) begin
      int op, c;
      bit t;
      op = int'($urandom_range(0, 9));
      c  = int'($urandom_range(0, 5));
      t  = ($urandom_range(0, 2) != 0);
      case (op)
        0, 1, 2: step(0, 0, 10'h0, 0, t, "R5");
        3: rd(cb(c, 8), "R7", t);
        4: rd(10'h004, "R5", t);
        5: step(1, 0, 10'h004, {26'd0, 6'($urandom)}, t, "R4");
        6: step(1, 0, cb(c, 4), $urandom_range(0, 7), t, "R7");
        7: step(1, 0, cb(c, 0), {24'd0, 1'($urandom), 5'd0, 2'($urandom)}, t, "R2");
        8: rd(cb(c, 0), "R6", t);
        default: step(1, 0, 10'h000, {26'd0, 6'($urandom)}, t, "R8");
      endcase
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule